// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Framing

This block turns parallel words into an asynchronous serial bit stream. Each data word is sent as one frame: a low start bit, the data bits with the least significant bit first, and a high stop bit. A mode bit chooses between 8-bit words (10-bit frames) and 9-bit words (11-bit frames). An external bit-rate tick advances every bit. Baud generation stays outside the block.

A small control register holds three bits: enable, break and word mode. Setting the enable bit queues one all-ones idle frame ahead of any data. Holding the break bit makes the block send all-zero frames back to back, each as long as a data frame. The frame on the line always runs to its end, so a break bit that is set and then cleared within one frame gives exactly one break frame. After the last break frame, at least one high bit time follows before new data starts. A one-word holding register with a ready flag accepts data from the host.

Top module: `sio_tx`

## Requirements
- R1: After reset the control register is cleared, so enable, break and mode are all 0. `txd` is 1 and `wr_ready` is 1. A `ctl_we` pulse loads `ctl_wdata`, where bit 0 is enable, bit 1 is break and bit 2 is 9-bit mode.
- R2: In 8-bit mode a data frame has 10 bits: a start bit of 0, then `wr_data[7:0]` with bit 0 first, then a stop bit of 1. `wr_data[8]` is not sent. `txd` changes only on a clock edge where `bit_tick` is high, and each bit lasts one tick interval.
- R3: In 9-bit mode a data frame has 11 bits: a start bit of 0, then `wr_data[8:0]` with bit 0 first, then a stop bit of 1.
- R4: When a control write changes enable from 0 to 1, one idle frame is queued. The idle frame is 10 bits (8-bit mode) or 11 bits (9-bit mode), all at 1, and it goes out before any held data.
- R5: While enable is 0 and no frame is running, `txd` stays at 1 and held data is not sent. A frame already running when enable drops finishes unchanged.
- R6: While break and enable are set, each break frame is all zeros: 10 bits in 8-bit mode, 11 bits in 9-bit mode.
- R7: Break frames follow each other with no gap for as long as the break bit stays set.
- R8: The choice of the next frame is made only at a frame boundary. A break bit set at a boundary and cleared before that break frame ends gives exactly one break frame.
- R9: After the last break frame, `txd` is 1 for at least one bit time before a data frame starts.
- R10: `wr_ready` is 1 exactly when the holding register is empty. A write with `wr_ready` low is ignored. The register empties when its word starts transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 enable, bit 1 break, bit 2 9-bit mode |
| wr_valid | input | 1 | Data write request |
| wr_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| wr_ready | output | 1 | Holding register is empty |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial output line, idle high |

## Verification
The data path is driven with words that are all zeros, all ones, alternating bits and asymmetric values, in both modes. All-zero and all-one words show a stuck line or a missing start or stop bit. The asymmetric words expose bit reversal and a ninth bit lost or shifted. An 8-bit word with bit 8 set shows whether the mode bit truly cuts the frame length. The break sequences cover a held break, a break cleared in the middle of a frame and a one-shot break. Together they separate the repeat logic, boundary-only sampling and the high gap after the break. The enable sequences place held data behind a rising enable and drop enable in the middle of a frame, which shows the idle preamble and the rule that a frame always completes.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

   typedef enum logic [2:0] {
      FK_NONE  = 3'd0,
      FK_DATA  = 3'd1,
      FK_IDLE  = 3'd2,
      FK_BREAK = 3'd3,
      FK_MARK  = 3'd4
   } frame_kind_e;

   localparam int CTL_W    = 3;
   localparam int CTL_EN   = 0;
   localparam int CTL_BRK  = 1;
   localparam int CTL_NINE = 2;

endpackage

// File: rtl/sio_tx_ctl.sv
module sio_tx_ctl
   import sio_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  frame_kind_e      load_kind,
   output logic             en,
   output logic             brk,
   output logic             nine,
   output logic             idle_pend,
   output logic             mark_pend
);

   logic en_rise;
   assign en_rise = ctl_we && ctl_wdata[CTL_EN] && !en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         brk  <= 1'b0;
         nine <= 1'b0;
      end else if (ctl_we) begin
         en   <= ctl_wdata[CTL_EN];
         brk  <= ctl_wdata[CTL_BRK];
         nine <= ctl_wdata[CTL_NINE];
      end
   end

   // idle preamble request: raised by an enable edge, dropped when the idle frame loads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_pend <= 1'b0;
      end else begin
         if (load_kind == FK_IDLE) idle_pend <= 1'b0;
         if (en_rise)              idle_pend <= 1'b1;
      end
   end

   // one high bit owed after a break run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_pend <= 1'b0;
      end else begin
         case (load_kind)
            FK_BREAK:        mark_pend <= 1'b1;
            FK_MARK, FK_IDLE: mark_pend <= 1'b0;
            default:         mark_pend <= mark_pend;
         endcase
      end
   end

   a_r4_idle_queued: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> idle_pend);

   a_r1_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (en == $past(ctl_wdata[CTL_EN]) && brk == $past(ctl_wdata[CTL_BRK])));

   a_r9_mark_owed: assert property (@(posedge clk) disable iff (!rst_n)
      (load_kind == FK_BREAK) |=> mark_pend);

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic              wr_ready,
   output logic              full,
   output logic [WORD_W-1:0] word
);

   assign wr_ready = !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         word <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_valid && !full) begin
         full <= 1'b1;
         word <= wr_data;
      end
   end

   a_r10_ignore_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> $stable(word));

   a_r10_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> wr_ready);

   a_r10_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full);

endmodule

// File: rtl/sio_tx_sched.sv
module sio_tx_sched
   import sio_tx_pkg::*;
(
   input  logic        boundary,
   input  logic        en,
   input  logic        brk,
   input  logic        idle_pend,
   input  logic        mark_pend,
   input  logic        full,
   output frame_kind_e kind
);

   // priority: break, idle preamble, owed mark bit, data
   always_comb begin
      kind = FK_NONE;
      if (boundary) begin
         if (en && brk)              kind = FK_BREAK;
         else if (en && idle_pend)   kind = FK_IDLE;
         else if (mark_pend)         kind = FK_MARK;
         else if (en && full)        kind = FK_DATA;
      end
   end

endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
   import sio_tx_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  frame_kind_e   kind,
   input  logic          nine,
   input  logic [BASE_W:0] word,
   output logic          txd,
   output logic          busy,
   output frame_kind_e   cur
);

   localparam int FMAX  = BASE_W + 3;
   localparam int CNT_W = $clog2(FMAX + 1);

   logic [FMAX-1:0]  data_frame;
   logic [FMAX-1:0]  frame;
   logic [CNT_W-1:0] len;
   logic [FMAX-2:0]  sh;
   logic [CNT_W-1:0] rem;

   assign data_frame[0] = 1'b0;
   for (genvar i = 0; i < BASE_W; i++) begin : g_bits
      assign data_frame[i+1] = word[i];
   end
   assign data_frame[BASE_W+1] = nine ? word[BASE_W] : 1'b1;
   assign data_frame[BASE_W+2] = 1'b1;

   always_comb begin
      case (kind)
         FK_DATA:  frame = data_frame;
         FK_BREAK: frame = '0;
         default:  frame = '1;
      endcase
      if (kind == FK_MARK) len = CNT_W'(1);
      else if (nine)       len = CNT_W'(FMAX);
      else                 len = CNT_W'(FMAX - 1);
   end

   assign busy = (rem != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd <= 1'b1;
         sh  <= '1;
         rem <= '0;
         cur <= FK_NONE;
      end else if (tick) begin
         if (rem == '0) begin
            if (kind != FK_NONE) begin
               txd <= frame[0];
               sh  <= frame[FMAX-1:1];
               rem <= len - CNT_W'(1);
               cur <= kind;
            end else begin
               txd <= 1'b1;
               cur <= FK_NONE;
            end
         end else begin
            txd <= sh[0];
            sh  <= {1'b1, sh[FMAX-2:1]};
            rem <= rem - CNT_W'(1);
         end
      end
   end

   a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));

   a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == FK_BREAK) |-> !txd);

   a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == FK_IDLE || cur == FK_MARK) |-> txd);

   a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rem < CNT_W'(FMAX));

endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_tx_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [2:0]       ctl_wdata,
   input  logic             wr_valid,
   input  logic [BASE_W:0]  wr_data,
   output logic             wr_ready,
   input  logic             bit_tick,
   output logic             txd
);

   localparam int WORD_W = BASE_W + 1;

   if (BASE_W < 5 || BASE_W > 16) begin : g_bad_width
      $error("sio_tx: BASE_W must lie in 5..16");
   end

   logic              en, brk, nine, idle_pend, mark_pend;
   logic              full, busy, boundary;
   logic [WORD_W-1:0] word;
   frame_kind_e       kind, cur;

   assign boundary = bit_tick && !busy;

   sio_tx_ctl i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .load_kind (kind),
      .en        (en),
      .brk       (brk),
      .nine      (nine),
      .idle_pend (idle_pend),
      .mark_pend (mark_pend)
   );

   sio_tx_hold #(.WORD_W(WORD_W)) i_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .take     (kind == FK_DATA),
      .wr_ready (wr_ready),
      .full     (full),
      .word     (word)
   );

   sio_tx_sched i_sched (
      .boundary  (boundary),
      .en        (en),
      .brk       (brk),
      .idle_pend (idle_pend),
      .mark_pend (mark_pend),
      .full      (full),
      .kind      (kind)
   );

   sio_tx_shift #(.BASE_W(BASE_W)) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (bit_tick),
      .kind  (kind),
      .nine  (nine),
      .word  (word),
      .txd   (txd),
      .busy  (busy),
      .cur   (cur)
   );

   a_r5_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !en) |=> txd);

   a_r9_no_data_after_break: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && cur == FK_BREAK && !brk) |=> txd);

endmodule

// File: tb/test_sio_tx.sv
module test_sio_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [2:0] ctl_wdata = 3'b000;
   logic       wr_valid = 1'b0;
   logic [8:0] wr_data = 9'h000;
   logic       wr_ready;
   logic       bit_tick = 1'b0;
   logic       txd;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sio_tx i_sio_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .wr_ready  (wr_ready),
      .bit_tick  (bit_tick),
      .txd       (txd)
   );

   // {nine, word}
   localparam logic [9:0] VEC [8] = '{
      {1'b0, 9'h000}, {1'b0, 9'h0FF}, {1'b0, 9'h0A5}, {1'b0, 9'h1C3},
      {1'b1, 9'h100}, {1'b1, 9'h0AA}, {1'b1, 9'h155}, {1'b1, 9'h0E1}
   };

   function automatic logic [31:0] frame_of(input logic nine, input logic [8:0] d);
      if (nine) return {21'h0, 1'b1, d[8:0], 1'b0};
      else      return {22'h0, 1'b1, d[7:0], 1'b0};
   endfunction

   function automatic int len_of(input logic nine);
      return nine ? 11 : 10;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_bits(input int n, output logic [31:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         step();
         got[i] = txd;
      end
   endtask

   task automatic ctl(input logic [2:0] v);
      @(negedge clk) begin ctl_we = 1'b1; ctl_wdata = v; end
      @(negedge clk) ctl_we = 1'b0;
   endtask

   task automatic put(input logic [8:0] d);
      @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
      @(negedge clk) wr_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] got, exp;
      logic        hold_v;
      int          len;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(txd === 1'b1, "R1 txd after reset", {31'b0, txd}, 32'h1);
      check(wr_ready === 1'b1, "R1 ready after reset", {31'b0, wr_ready}, 32'h1);

      // R10: write fills, write while full ignored; R1/R5: no sending while disabled
      put(9'h03C);
      check(wr_ready === 1'b0, "R10 ready low when full", {31'b0, wr_ready}, 32'h0);
      put(9'h099);
      run_bits(12, got);
      check(got[11:0] === 12'hFFF, "R1 R5 disabled after reset", got, 32'hFFF);

      // R4: enable rising queues idle frame ahead of held data
      ctl(3'b001);
      run_bits(10, got);
      check(got[9:0] === 10'h3FF, "R4 idle frame 8-bit", got, 32'h3FF);
      run_bits(10, got);
      exp = frame_of(1'b0, 9'h03C);
      check(got[9:0] === exp[9:0], "R10 R2 held word kept, second write ignored", got, exp);
      check(wr_ready === 1'b1, "R10 ready after load", {31'b0, wr_ready}, 32'h1);

      // main table: R2 8-bit frames, R3 9-bit frames
      foreach (VEC[k]) begin
         ctl({VEC[k][9], 2'b01});
         put(VEC[k][8:0]);
         check(wr_ready === 1'b0, "R10 ready low after write", {31'b0, wr_ready}, 32'h0);
         len = len_of(VEC[k][9]);
         run_bits(len, got);
         exp = frame_of(VEC[k][9], VEC[k][8:0]);
         if (VEC[k][9]) check(got[10:0] === exp[10:0], "R3 9-bit frame", got, exp);
         else           check(got[9:0] === exp[9:0], "R2 8-bit frame", got, exp);
      end

      // R6 R7: held break gives back-to-back zero frames
      ctl(3'b011);
      run_bits(20, got);
      check(got[19:0] === 20'h0, "R6 R7 two back-to-back 8-bit breaks", got, 32'h0);
      run_bits(3, got);
      put(9'h081);
      ctl(3'b001);
      run_bits(7, got);
      check(got[9:0] === 10'h0, "R8 break frame completes after clear", got, 32'h0);
      run_bits(1, got);
      check(got[0] === 1'b1, "R9 high bit after break", got, 32'h1);
      run_bits(10, got);
      exp = frame_of(1'b0, 9'h081);
      check(got[9:0] === exp[9:0], "R9 data after break gap", got, exp);

      // R8 R6: one-shot break in 9-bit mode, 11 zeros then high
      ctl(3'b111);
      run_bits(1, got);
      ctl(3'b101);
      run_bits(10, exp);
      got = {exp[30:0], got[0]};
      run_bits(1, exp);
      got[11] = exp[0];
      check(got[11:0] === 12'h800, "R8 R6 single 9-bit break frame", got, 32'h800);
      run_bits(3, got);
      check(got[2:0] === 3'b111, "R8 no further break", got, 32'h7);

      // R5: enable dropped mid-frame, frame still completes
      ctl(3'b001);
      put(9'h0E7);
      run_bits(4, got);
      hold_v = txd;
      repeat (5) @(negedge clk);
      check(txd === hold_v, "R2 txd stable without tick", {31'b0, txd}, {31'b0, hold_v});
      ctl(3'b000);
      run_bits(6, exp);
      got = {exp[27:0], got[3:0]};
      exp = frame_of(1'b0, 9'h0E7);
      check(got[9:0] === exp[9:0], "R5 frame completes after disable", got, exp);
      put(9'h042);
      run_bits(12, got);
      check(got[11:0] === 12'hFFF, "R5 disabled holds line high", got, 32'hFFF);
      check(wr_ready === 1'b0, "R5 R10 word still held", {31'b0, wr_ready}, 32'h0);

      // R4 in 9-bit mode: 11 ones before data
      ctl(3'b101);
      run_bits(11, got);
      check(got[10:0] === 11'h7FF, "R4 idle frame 9-bit", got, 32'h7FF);
      run_bits(11, got);
      exp = frame_of(1'b1, 9'h042);
      check(got[10:0] === exp[10:0], "R3 data after idle", got, exp);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule